// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block steps the column address of a synchronous DRAM-style memory controller through a burst. A stored mode setting gives the burst length (1, 2 or 4 accesses) and the burst order (sequential or interleave). A read or write command carries a starting column. From the next clock on, the block presents one column address per clock until the burst is done. The row address is not handled here, because it stays the same for the whole burst.

A read or write command that arrives while a burst is running discards the rest of that burst. The count restarts from the new column in the next clock, and the direction follows the new command. A precharge command stops a running burst. A last-beat flag marks the final address. If no new command arrives on that beat, the block goes idle. The mode setting can only be changed while the block is idle.

Top module: `burst_col_seq`

## Requirements
- R1: While reset (rst_n low, active low) is asserted, idle is 1 and col_valid and col_last are 0.
- R2: cmd encodings are 0 = none, 1 = read, 2 = write and 3 = precharge. After a read or write command, the next clock shows col_valid = 1 and col_out equal to cmd_col. col_is_wr is 1 for a write and 0 for a read.
- R3: The length code mode_len gives the burst length: 0 gives 1 beat, 1 gives 2 beats, and 2 or 3 give 4 beats. An uninterrupted burst holds col_valid for exactly that many consecutive clocks.
- R4: With mode_ilv = 0 (sequential), the low log2(length) address bits of each beat are the start value plus the beat index, modulo the length. For example, start 5 with length 4 gives 5, 6, 7, 4.
- R5: With mode_ilv = 1 (interleave), the low log2(length) address bits of each beat are the start value XOR the beat index. For example, start 5 with length 4 gives 5, 4, 7, 6, and start 0xF2 with length 2 gives 0xF2, 0xF3.
- R6: With length 1, the order setting has no effect: the single beat is the start column.
- R7: Column bits above the burst boundary keep their start value for the whole burst. For example, start 0x1FE with length 4 gives 0x1FE, 0x1FF, 0x1FC, 0x1FD in sequential order.
- R8: A read or write command during a burst cuts that burst off after the current beat. The next clock shows beat 0 at the new column.
- R9: A precharge command during a burst ends it. The next clock shows idle = 1 and col_valid = 0.
- R10: mode_load is ignored while a burst is running, and also in a cycle that carries a read or write command. Later bursts keep the previous length and order.
- R11: col_last is 1 exactly on the final beat of a burst. If cmd is none on that beat, the next clock is idle. If a read or write command arrives on that beat, the next burst follows with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_load | input | 1 | Load mode_len and mode_ilv into the mode setting |
| mode_len | input | CODE_W (2) | Burst length code: length = 2^min(code, MAX_LOG2) |
| mode_ilv | input | 1 | Order: 0 = sequential, 1 = interleave |
| cmd | input | 2 | Command: 0 none, 1 read, 2 write, 3 precharge |
| cmd_col | input | COL_W (9) | Starting column for a read or write |
| col_out | output | COL_W (9) | Column address of the current beat |
| col_valid | output | 1 | col_out holds a beat of a running burst |
| col_last | output | 1 | The current beat is the final beat of the burst |
| col_is_wr | output | 1 | The running burst is a write |
| idle | output | 1 | No burst is running |

## Verification
The same starting column is run through sequential and interleave order at length 4, with start 5. The two orders give different sequences there, so a swapped or merged order is exposed. Starts that sit near the top of the column range show whether the wrap stays inside the boundary or carries into the upper bits. Length 1 and length 2 runs, and length code 3, show whether the length decode is correct.

Bursts are cut short by a restart, by a precharge and by a back-to-back command on the last beat. These runs check how many beats come out and when idle returns. Mode loads are tried during a burst and together with a command, and a follow-up burst then shows whether either load was wrongly accepted.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
   typedef enum logic [1:0] {
      CMD_NOP   = 2'd0,
      CMD_READ  = 2'd1,
      CMD_WRITE = 2'd2,
      CMD_PRE   = 2'd3
   } bcs_cmd_e;
endpackage

// File: rtl/bcs_mode_reg.sv
module bcs_mode_reg #(
   parameter int MAX_LOG2 = 2,
   parameter int CODE_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_req,
   input  logic              block,
   input  logic [CODE_W-1:0] code_in,
   input  logic              ilv_in,
   output logic [CODE_W-1:0] len_log2,
   output logic              ilv
);
   localparam logic [CODE_W-1:0] CODE_MAX = CODE_W'(MAX_LOG2);

   logic [CODE_W-1:0] code_clip;

   // out-of-range codes fold onto the longest burst at load time
   always_comb begin
      code_clip = (code_in > CODE_MAX) ? CODE_MAX : code_in;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         len_log2 <= '0;
         ilv      <= 1'b0;
      end else if (load_req && !block) begin
         len_log2 <= code_clip;
         ilv      <= ilv_in;
      end
   end
endmodule

// File: rtl/bcs_beat_ctrl.sv
module bcs_beat_ctrl
   import bcs_pkg::*;
#(
   parameter int COL_W  = 9,
   parameter int CNT_W  = 2,
   parameter int CODE_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  bcs_cmd_e          cmd,
   input  logic [COL_W-1:0]  cmd_col,
   input  logic [CODE_W-1:0] len_log2,
   output logic              active,
   output logic [CNT_W-1:0]  cnt,
   output logic [COL_W-1:0]  start,
   output logic              is_wr,
   output logic              last
);
   logic [CNT_W-1:0] final_idx;
   logic             start_req;

   always_comb begin
      final_idx = CNT_W'((32'd1 << len_log2) - 32'd1);
      start_req = (cmd == CMD_READ) || (cmd == CMD_WRITE);
      last      = active && (cnt == final_idx);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         cnt    <= '0;
         start  <= '0;
         is_wr  <= 1'b0;
      end else if (start_req) begin
         // new command always wins, even mid-burst
         active <= 1'b1;
         cnt    <= '0;
         start  <= cmd_col;
         is_wr  <= (cmd == CMD_WRITE);
      end else if (cmd == CMD_PRE) begin
         active <= 1'b0;
         cnt    <= '0;
      end else if (active) begin
         if (last) begin
            active <= 1'b0;
            cnt    <= '0;
         end else begin
            cnt <= cnt + CNT_W'(1);
         end
      end
   end
endmodule

// File: rtl/bcs_addr_gen.sv
module bcs_addr_gen #(
   parameter int COL_W  = 9,
   parameter int CNT_W  = 2,
   parameter int CODE_W = 2
) (
   input  logic [COL_W-1:0]  start,
   input  logic [CNT_W-1:0]  cnt,
   input  logic [CODE_W-1:0] len_log2,
   input  logic              ilv,
   output logic [COL_W-1:0]  col
);
   logic [CNT_W-1:0] wrap_mask;
   logic [CNT_W-1:0] seq_low;
   logic [CNT_W-1:0] ilv_low;
   logic [CNT_W-1:0] pick_low;

   always_comb begin
      wrap_mask = CNT_W'((32'd1 << len_log2) - 32'd1);
      seq_low   = start[CNT_W-1:0] + cnt;
      ilv_low   = start[CNT_W-1:0] ^ cnt;
      pick_low  = ilv ? ilv_low : seq_low;
   end

   for (genvar i = 0; i < CNT_W; i++) begin : g_low
      assign col[i] = wrap_mask[i] ? pick_low[i] : start[i];
   end

   if (COL_W > CNT_W) begin : g_high
      assign col[COL_W-1:CNT_W] = start[COL_W-1:CNT_W];
   end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
   import bcs_pkg::*;
#(
   parameter  int COL_W    = 9,
   parameter  int MAX_LOG2 = 2,
   localparam int CODE_W   = $clog2(MAX_LOG2 + 1),
   localparam int CNT_W    = MAX_LOG2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_load,
   input  logic [CODE_W-1:0] mode_len,
   input  logic              mode_ilv,
   input  logic [1:0]        cmd,
   input  logic [COL_W-1:0]  cmd_col,
   output logic [COL_W-1:0]  col_out,
   output logic              col_valid,
   output logic              col_last,
   output logic              col_is_wr,
   output logic              idle
);
   if (MAX_LOG2 < 1) begin : g_bad_len
      $error("burst_col_seq: MAX_LOG2 must be at least 1");
   end
   if (COL_W <= MAX_LOG2) begin : g_bad_col
      $error("burst_col_seq: COL_W must exceed MAX_LOG2");
   end

   bcs_cmd_e          cmd_e;
   logic [CODE_W-1:0] len_q;
   logic              ilv_q;
   logic              active;
   logic [CNT_W-1:0]  cnt;
   logic [COL_W-1:0]  start;
   logic              mode_block;

   always_comb begin
      cmd_e      = bcs_cmd_e'(cmd);
      mode_block = active || (cmd_e == CMD_READ) || (cmd_e == CMD_WRITE);
   end

   bcs_mode_reg #(.MAX_LOG2(MAX_LOG2), .CODE_W(CODE_W)) u_mode (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_req (mode_load),
      .block    (mode_block),
      .code_in  (mode_len),
      .ilv_in   (mode_ilv),
      .len_log2 (len_q),
      .ilv      (ilv_q)
   );

   bcs_beat_ctrl #(.COL_W(COL_W), .CNT_W(CNT_W), .CODE_W(CODE_W)) u_beat (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd      (cmd_e),
      .cmd_col  (cmd_col),
      .len_log2 (len_q),
      .active   (active),
      .cnt      (cnt),
      .start    (start),
      .is_wr    (col_is_wr),
      .last     (col_last)
   );

   bcs_addr_gen #(.COL_W(COL_W), .CNT_W(CNT_W), .CODE_W(CODE_W)) u_addr (
      .start    (start),
      .cnt      (cnt),
      .len_log2 (len_q),
      .ilv      (ilv_q),
      .col      (col_out)
   );

   assign col_valid = active;
   assign idle      = !active;
endmodule

// File: rtl/bcs_chk.sv
module bcs_chk
   import bcs_pkg::*;
#(
   parameter int COL_W  = 9,
   parameter int CNT_W  = 2,
   parameter int CODE_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        cmd,
   input logic [COL_W-1:0]  cmd_col,
   input logic [COL_W-1:0]  col_out,
   input logic              col_valid,
   input logic              col_last,
   input logic              idle,
   input logic [CODE_W-1:0] len_q,
   input logic              ilv_q
);
   assert_start_col_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_READ || cmd == CMD_WRITE) |=> (col_valid && col_out == $past(cmd_col)));

   assert_upper_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (col_valid && !col_last && cmd == CMD_NOP)
      |=> (col_out[COL_W-1:CNT_W] == $past(col_out[COL_W-1:CNT_W])));

   assert_pre_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_PRE) |=> (idle && !col_valid));

   assert_mode_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !idle |=> ($stable(len_q) && $stable(ilv_q)));

   assert_last_in_burst_R11: assert property (@(posedge clk) disable iff (!rst_n)
      col_last |-> col_valid);

   assert_idle_after_last_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (col_last && cmd == CMD_NOP) |=> idle);
endmodule

bind burst_col_seq bcs_chk #(.COL_W(COL_W), .CNT_W(CNT_W), .CODE_W(CODE_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd       (cmd),
   .cmd_col   (cmd_col),
   .col_out   (col_out),
   .col_valid (col_valid),
   .col_last  (col_last),
   .idle      (idle),
   .len_q     (len_q),
   .ilv_q     (ilv_q)
);

// File: tb/tb_burst_col_seq.sv
`timescale 1ns/1ps
module tb_burst_col_seq;
   import bcs_pkg::*;
   localparam int COL_W = 9;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             mode_load = 1'b0;
   logic [1:0]       mode_len = '0;
   logic             mode_ilv = 1'b0;
   logic [1:0]       cmd = CMD_NOP;
   logic [COL_W-1:0] cmd_col = '0;
   logic [COL_W-1:0] col_out;
   logic             col_valid, col_last, col_is_wr, idle;

   always #2.5 clk = ~clk;

   burst_col_seq #(.COL_W(COL_W), .MAX_LOG2(2)) dut (
      .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_len(mode_len),
      .mode_ilv(mode_ilv), .cmd(cmd), .cmd_col(cmd_col), .col_out(col_out),
      .col_valid(col_valid), .col_last(col_last), .col_is_wr(col_is_wr), .idle(idle)
   );

   typedef struct {
      logic [COL_W-1:0] col;
      logic             last;
      logic             wr;
      string            tag;
   } exp_t;

   exp_t  sb[$];
   int    checks = 0;
   int    errors = 0;
   bit    mon_on = 0;
   bit    done = 0;
   int    m_len = 1;
   bit    m_ilv = 0;

   function automatic logic [COL_W-1:0] exp_col(logic [COL_W-1:0] s, int n, int len, bit il);
      logic [COL_W-1:0] mk, low;
      mk  = COL_W'(len - 1);
      low = il ? (s ^ COL_W'(n)) : (s + COL_W'(n));
      return (s & ~mk) | (low & mk);
   endfunction

   task automatic check(bit ok, string tag, string what, longint act, longint expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
      end
   endtask

   // scoreboard monitor: every valid beat must match the head of the queue
   always @(negedge clk) begin
      if (mon_on && col_valid) begin
         exp_t e;
         if (sb.size() == 0) begin
            check(1'b0, "R3", "unexpected beat col", col_out, 0);
         end else begin
            e = sb.pop_front();
            check(col_out == e.col, e.tag, "col_out", col_out, e.col);
            check(col_last == e.last, e.tag, "col_last", col_last, e.last);
            check(col_is_wr == e.wr, e.tag, "col_is_wr", col_is_wr, e.wr);
         end
      end
   end

   // driver: issue a command, push the beats expected before the cut
   task automatic run_burst(logic [1:0] c, logic [COL_W-1:0] a, int cut, int hold, string tag);
      int n;
      n = (cut < m_len) ? cut : m_len;
      for (int i = 0; i < n; i++) begin
         exp_t e;
         e.col  = exp_col(a, i, m_len, m_ilv);
         e.last = (i == m_len - 1);
         e.wr   = (c == CMD_WRITE);
         e.tag  = tag;
         sb.push_back(e);
      end
      cmd = c;
      cmd_col = a;
      @(negedge clk);
      cmd = CMD_NOP;
      repeat (hold - 1) @(negedge clk);
   endtask

   task automatic set_mode(logic [1:0] code, bit il, bit accept);
      mode_load = 1'b1;
      mode_len  = code;
      mode_ilv  = il;
      @(negedge clk);
      mode_load = 1'b0;
      if (accept) begin
         m_len = 1 << ((code > 2) ? 2 : code);
         m_ilv = il;
      end
   endtask

   task automatic drain(string tag, int gap);
      repeat (gap) @(negedge clk);
      #1;
      check(sb.size() == 0, tag, "pending beats", sb.size(), 0);
      check(idle == 1'b1, tag, "idle after burst", idle, 1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R3 watchdog actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      // R1: reset state
      check(idle == 1'b1, "R1", "idle in reset", idle, 1);
      check(col_valid == 1'b0, "R1", "col_valid in reset", col_valid, 0);
      check(col_last == 1'b0, "R1", "col_last in reset", col_last, 0);
      rst_n = 1'b1;
      mon_on = 1;
      @(negedge clk);

      // R2/R3: reset mode is length 1, read then write
      run_burst(CMD_READ, 9'h0A3, 9, 1, "R2");
      drain("R3", 3);
      run_burst(CMD_WRITE, 9'h0A3, 9, 1, "R2");
      drain("R2", 3);

      // R6: interleave at length 1 changes nothing
      set_mode(2'd0, 1'b1, 1'b1);
      run_burst(CMD_WRITE, 9'h0A3, 9, 1, "R6");
      drain("R6", 3);

      // R4: sequential, length 4, start 5 -> 5,6,7,4
      set_mode(2'd2, 1'b0, 1'b1);
      run_burst(CMD_READ, 9'h005, 9, 4, "R4");
      drain("R11", 1);
      // R7: sequential wrap at top of range
      run_burst(CMD_READ, 9'h1FE, 9, 4, "R7");
      drain("R7", 2);

      // R5: interleave, length 4, start 5 -> 5,4,7,6
      set_mode(2'd2, 1'b1, 1'b1);
      run_burst(CMD_WRITE, 9'h005, 9, 4, "R5");
      drain("R5", 2);
      run_burst(CMD_READ, 9'h1FE, 9, 4, "R7");
      drain("R7", 2);

      // R3/R4/R5: length 2 in both orders
      set_mode(2'd1, 1'b0, 1'b1);
      run_burst(CMD_READ, 9'h0F3, 9, 2, "R4");
      drain("R3", 2);
      set_mode(2'd1, 1'b1, 1'b1);
      run_burst(CMD_READ, 9'h0F2, 9, 2, "R5");
      drain("R3", 2);

      // R3: code 3 folds onto length 4
      set_mode(2'd3, 1'b0, 1'b1);
      run_burst(CMD_READ, 9'h010, 9, 4, "R3");
      drain("R3", 2);

      // R8: restart after two beats, read and write
      run_burst(CMD_READ, 9'h020, 2, 2, "R8");
      run_burst(CMD_READ, 9'h042, 9, 4, "R8");
      drain("R8", 2);
      run_burst(CMD_WRITE, 9'h031, 1, 1, "R8");
      run_burst(CMD_WRITE, 9'h13B, 9, 4, "R8");
      drain("R8", 2);

      // R11: command on the final beat gives back-to-back bursts
      run_burst(CMD_WRITE, 9'h060, 4, 4, "R11");
      run_burst(CMD_READ, 9'h077, 9, 4, "R11");
      drain("R11", 2);

      // R9: precharge after two beats
      run_burst(CMD_READ, 9'h080, 2, 2, "R9");
      cmd = CMD_PRE;
      @(negedge clk);
      cmd = CMD_NOP;
      #1;
      check(idle == 1'b1, "R9", "idle after precharge", idle, 1);
      check(col_valid == 1'b0, "R9", "col_valid after precharge", col_valid, 0);
      drain("R9", 2);

      // R10: load during a burst is ignored
      run_burst(CMD_READ, 9'h090, 9, 1, "R10");
      set_mode(2'd0, 1'b1, 1'b0);
      drain("R10", 4);
      run_burst(CMD_READ, 9'h095, 9, 4, "R10");
      drain("R10", 2);

      // R10: load in the same cycle as a command is ignored
      begin
         for (int i = 0; i < 4; i++) begin
            exp_t e;
            e.col  = exp_col(9'h0A1, i, m_len, m_ilv);
            e.last = (i == 3);
            e.wr   = 1'b0;
            e.tag  = "R10";
            sb.push_back(e);
         end
         cmd = CMD_READ;
         cmd_col = 9'h0A1;
         mode_load = 1'b1;
         mode_len = 2'd0;
         mode_ilv = 1'b1;
         @(negedge clk);
         cmd = CMD_NOP;
         mode_load = 1'b0;
         repeat (3) @(negedge clk);
      end
      drain("R10", 2);
      run_burst(CMD_WRITE, 9'h0B5, 9, 4, "R10");
      drain("R10", 2);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule